// File: doc/BRIEF.md
# 100 Mbps Link Integrity Monitor

This block decides whether a 100 Mbps receive link is up. It watches two signals from the receive path. One is a descrambler-lock level. The other is a per-symbol strobe with an idle qualifier. The block drives a live link flag, a sticky failure bit, an interrupt pulse, a renegotiation request and a gated transmit enable.

Bringing the link up takes a long qualification: lock must stay high without a break for a programmable number of cycles. Once the link is up, lock is no longer consulted. A supervision window then keeps the link alive. Each window must contain a run of consecutive idle symbols of a set minimum length. A window that closes without such a run takes the link down. Timer lengths are parameters, so a simulation can use short values in place of the real 50 ms and 2 ms intervals.

Top module: `lnk100_monitor`

## Requirements
- R1: With the link down, `link_up_o` rises right after the LOCK_CYCLES-th consecutive rising clock edge at which `lock_i` is high.
- R2: While the link is down, a single cycle with `lock_i` low restarts the qualification count from zero.
- R3: While the link is up, `lock_i` has no effect; only the idle supervision can take the link down.
- R4: While the link is up, each cycle with `sym_valid_i` high and `sym_idle_i` high extends an idle run. A valid non-idle symbol clears the run. Cycles without `sym_valid_i` leave the run unchanged. When the run reaches IDLE_RUN, the supervision window restarts and the run starts again from zero.
- R5: The window opens on the first cycle of link-up and on every restart. If WINDOW_CYCLES cycles pass in it without the run reaching IDLE_RUN, `link_up_o` falls at the edge that ends the last of those cycles.
- R6: `fail_lat_o` is set in the same cycle that `link_up_o` falls. It is cleared by a cycle with `stat_rd_i` high. A new failure in that same cycle wins over the clear.
- R7: `irq_o` is high for exactly the one cycle in which `link_up_o` has just changed (either direction), and only if `irq_en_i` was high at the edge that changed it.
- R8: `renego_o` is high for the one cycle in which `link_up_o` has just fallen, and only if `aneg_en_i` was high at that edge.
- R9: `tx_en_o` equals `tx_en_i` while `link_up_o` or `tx_force_i` is high, and is 0 otherwise (combinational).
- R10: After reset, `link_up_o`, `fail_lat_o`, `irq_o` and `renego_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Descrambler lock level |
| sym_valid_i | input | 1 | One received symbol this cycle |
| sym_idle_i | input | 1 | Symbol of this cycle is idle |
| aneg_en_i | input | 1 | Auto-negotiation enabled |
| irq_en_i | input | 1 | Interrupt enable |
| stat_rd_i | input | 1 | Status read strobe, clears sticky fail bit |
| tx_force_i | input | 1 | Diagnostic override: allow transmit with link down |
| tx_en_i | input | 1 | Transmit enable request from the MAC side |
| link_up_o | output | 1 | Live link state |
| fail_lat_o | output | 1 | Sticky link-failure status |
| irq_o | output | 1 | One-cycle pulse on link change |
| renego_o | output | 1 | One-cycle renegotiation request on failure |
| tx_en_o | output | 1 | Gated transmit enable |

## Verification
Suppose the qualification counter holds a wrong value. Then `link_up_o` rises one or more cycles away from the LOCK_CYCLES-th lock edge, and a lockstep reference exposes this in the first cycle of the mismatch. Suppose instead the window or run counter drifts, for example by failing to clear on a non-idle symbol or on a restart. Then the link falls at a different edge than predicted, or it stays up when it should fall. This shows at the ports no later than one window length after the error. Sticky-bit, interrupt and renegotiation errors show up in the single cycle of the transition itself.

// File: rtl/lnk100_pkg.sv
package lnk100_pkg;
  typedef enum logic {
    LNK_DOWN = 1'b0,
    LNK_UP   = 1'b1
  } lnk_st_e;
endpackage

// File: rtl/lnk100_lock_qual.sv
module lnk100_lock_qual #(
  parameter int unsigned LOCK_CYCLES = 6250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lock_i,
  output logic qual_o
);
  localparam int unsigned LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LW-1:0] LAST = LW'(LOCK_CYCLES - 1);

  logic [LW-1:0] cnt_q;

  assign qual_o = en_i && lock_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i || !lock_i || qual_o) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  // R2
  lock_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R1
  qual_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> $past(lock_i) || (cnt_q == '0));
endmodule

// File: rtl/lnk100_idle_window.sv
module lnk100_idle_window #(
  parameter int unsigned WINDOW_CYCLES = 250000,
  parameter int unsigned IDLE_RUN      = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic sym_valid_i,
  input  logic sym_idle_i,
  output logic expire_o
);
  localparam int unsigned WW = $clog2(WINDOW_CYCLES + 1);
  localparam int unsigned RW = $clog2(IDLE_RUN + 1);
  localparam logic [WW-1:0] WLAST = WW'(WINDOW_CYCLES - 1);
  localparam logic [RW-1:0] RLAST = RW'(IDLE_RUN - 1);

  logic [WW-1:0] win_q;
  logic [RW-1:0] run_q;
  logic          hit;

  assign hit      = active_i && sym_valid_i && sym_idle_i && (run_q == RLAST);
  assign expire_o = active_i && !hit && (win_q == WLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      run_q <= '0;
    end else if (!active_i || hit) begin
      win_q <= '0;
      run_q <= '0;
    end else begin
      win_q <= expire_o ? '0 : win_q + 1'b1;
      if (sym_valid_i) run_q <= sym_idle_i ? run_q + 1'b1 : '0;
    end
  end

  // R4
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RLAST);
  // R5
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= WLAST);
  // R4
  run_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && sym_valid_i && !sym_idle_i) |=> (run_q == '0));
endmodule

// File: rtl/lnk100_status.sv
module lnk100_status
  import lnk100_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  input  logic expire_i,
  input  logic aneg_en_i,
  input  logic irq_en_i,
  input  logic stat_rd_i,
  output logic link_up_o,
  output logic fail_lat_o,
  output logic irq_o,
  output logic renego_o
);
  lnk_st_e st_q, st_d;
  logic    fail_evt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LNK_DOWN: if (qual_i)   st_d = LNK_UP;
      LNK_UP:   if (expire_i) st_d = LNK_DOWN;
      default:  st_d = LNK_DOWN;
    endcase
  end

  assign fail_evt  = (st_q == LNK_UP) && (st_d == LNK_DOWN);
  assign link_up_o = (st_q == LNK_UP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= LNK_DOWN;
      fail_lat_o <= 1'b0;
      irq_o      <= 1'b0;
      renego_o   <= 1'b0;
    end else begin
      st_q       <= st_d;
      irq_o      <= irq_en_i && (st_d != st_q);
      renego_o   <= aneg_en_i && fail_evt;
      if (fail_evt)       fail_lat_o <= 1'b1;
      else if (stat_rd_i) fail_lat_o <= 1'b0;
    end
  end

  // R6
  fail_sets_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_up_o) |-> fail_lat_o);
  // R7
  irq_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (link_up_o != $past(link_up_o)));
  // R8
  renego_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    renego_o |-> $fell(link_up_o));
endmodule

// File: rtl/lnk100_monitor.sv
module lnk100_monitor #(
  parameter int unsigned LOCK_CYCLES   = 6250000,
  parameter int unsigned WINDOW_CYCLES = 250000,
  parameter int unsigned IDLE_RUN      = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic sym_valid_i,
  input  logic sym_idle_i,
  input  logic aneg_en_i,
  input  logic irq_en_i,
  input  logic stat_rd_i,
  input  logic tx_force_i,
  input  logic tx_en_i,
  output logic link_up_o,
  output logic fail_lat_o,
  output logic irq_o,
  output logic renego_o,
  output logic tx_en_o
);
  logic qual, expire, up;

  lnk100_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!up),
    .lock_i (lock_i),
    .qual_o (qual)
  );

  lnk100_idle_window #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .IDLE_RUN      (IDLE_RUN)
  ) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (up),
    .sym_valid_i (sym_valid_i),
    .sym_idle_i  (sym_idle_i),
    .expire_o    (expire)
  );

  lnk100_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .qual_i     (qual),
    .expire_i   (expire),
    .aneg_en_i  (aneg_en_i),
    .irq_en_i   (irq_en_i),
    .stat_rd_i  (stat_rd_i),
    .link_up_o  (up),
    .fail_lat_o (fail_lat_o),
    .irq_o      (irq_o),
    .renego_o   (renego_o)
  );

  assign link_up_o = up;
  assign tx_en_o   = tx_en_i && (up || tx_force_i);

  // R1
  rise_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_o) |-> $past(lock_i));
  // R9
  tx_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_up_o && !tx_force_i) |-> !tx_en_o);
endmodule

// File: tb/lnk100_monitor_bench.sv
module lnk100_monitor_bench;
  localparam int PERIOD = 10;
  localparam int L = 40;
  localparam int W = 80;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 0, sv = 0, idle = 0, aneg = 0, ien = 0, rd = 0, force_tx = 0, txen = 0;
  logic link_up, fail_lat, irq, renego, tx_en;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  lnk100_monitor #(.LOCK_CYCLES(L), .WINDOW_CYCLES(W), .IDLE_RUN(N)) u_lnk100_monitor (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .sym_valid_i(sv), .sym_idle_i(idle),
    .aneg_en_i(aneg), .irq_en_i(ien), .stat_rd_i(rd), .tx_force_i(force_tx),
    .tx_en_i(txen), .link_up_o(link_up), .fail_lat_o(fail_lat), .irq_o(irq),
    .renego_o(renego), .tx_en_o(tx_en)
  );

  // reference model built from the requirements
  int m_lc, m_win, m_run;
  bit m_up, m_lat, m_irq, m_ren;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lc = 0; m_win = 0; m_run = 0;
      m_up = 0; m_lat = 0; m_irq = 0; m_ren = 0;
    end else begin
      bit rise, fall, hit;
      rise = 0; fall = 0;
      if (!m_up) begin
        if (!lock) m_lc = 0;
        else if (m_lc == L-1) begin rise = 1; m_lc = 0; end
        else m_lc++;
      end else begin
        hit = sv && idle && (m_run == N-1);
        if (hit) begin m_win = 0; m_run = 0; end
        else begin
          if (sv) m_run = idle ? m_run + 1 : 0;
          if (m_win == W-1) fall = 1; else m_win++;
        end
      end
      if (rise) begin m_up = 1; m_win = 0; m_run = 0; end
      if (fall) begin m_up = 0; m_lc = 0; end
      m_irq = ien && (rise || fall);
      m_ren = aneg && fall;
      if (fall) m_lat = 1; else if (rd) m_lat = 0;
    end
  end

  function automatic bit exp_tx(bit up, bit f, bit t);
    return t && (up || f);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(link_up == m_up, "R1/R2/R3/R5", "link_up", link_up, m_up);
    chk(fail_lat == m_lat, "R6", "fail_lat", fail_lat, m_lat);
    chk(irq == m_irq, "R7", "irq", irq, m_irq);
    chk(renego == m_ren, "R8", "renego", renego, m_ren);
    chk(tx_en == exp_tx(m_up, force_tx, txen), "R9", "tx_en", tx_en, exp_tx(m_up, force_tx, txen));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(PERIOD*150000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(PERIOD*3);
    @(negedge clk);
    // R10 reset state
    chk(!link_up && !fail_lat && !irq && !renego, "R10", "reset outputs",
        {link_up, fail_lat, irq, renego}, 0);
    rst_n = 1;
    ien = 1; aneg = 1;
    // R2: L-1 lock cycles, one drop, then full qualification
    lock = 1; run(L-1);
    chk(link_up == 0, "R2", "not up before L", link_up, 0);
    lock = 0; tick();
    lock = 1; run(L-1);
    chk(link_up == 0, "R2", "restart after drop", link_up, 0);
    tick();
    chk(link_up == 1, "R1", "up at L-th edge", link_up, 1);
    chk(irq == 1, "R7", "irq on rise", irq, 1);
    // R3/R4: lock lost, idles keep link up
    lock = 0; sv = 1; idle = 1; run(3*W);
    chk(link_up == 1, "R3", "lock ignored while up", link_up, 1);
    // R4: gaps in sym_valid do not break runs
    for (int i = 0; i < 2*W; i++) begin sv = i[0]; idle = 1; tick(); end
    chk(link_up == 1, "R4", "gapped idle run", link_up, 1);
    // R5: runs of N-1 then a non-idle symbol -> fail
    for (int i = 0; i < W+N; i++) begin sv = 1; idle = (i % N) != N-1; tick(); end
    chk(link_up == 0, "R5", "short runs drop link", link_up, 0);
    chk(fail_lat == 1, "R6", "latched fail", fail_lat, 1);
    sv = 0; idle = 0;
    rd = 1; tick(); rd = 0;
    chk(fail_lat == 0, "R6", "clear on read", fail_lat, 0);
    // R9: override
    txen = 1; force_tx = 1; tick();
    chk(tx_en == 1, "R9", "force while down", tx_en, 1);
    force_tx = 0; tick();
    chk(tx_en == 0, "R9", "blocked while down", tx_en, 0);
    // R7/R8 gating: qualify with irq/aneg off, then expire with rd held
    ien = 0; aneg = 0; lock = 1; run(L);
    chk(link_up == 1 && irq == 0, "R7", "irq gated", irq, 0);
    lock = 0; rd = 1; run(W);
    chk(link_up == 0 && renego == 0, "R8", "renego gated", renego, 0);
    chk(fail_lat == 1, "R6", "set wins over read", fail_lat, 1);
    rd = 0;
    // random phases
    for (int p = 0; p < 60; p++) begin
      int pl, pi, pv;
      pl = $urandom_range(100, 60);
      pi = $urandom_range(100, 80);
      pv = $urandom_range(100, 50);
      for (int c = 0; c < 400; c++) begin
        lock = ($urandom_range(99) < pl);
        sv = ($urandom_range(99) < pv);
        idle = ($urandom_range(99) < pi);
        ien = $urandom_range(1); aneg = $urandom_range(1);
        rd = ($urandom_range(9) == 0);
        force_tx = $urandom_range(1); txen = $urandom_range(1);
        tick();
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule